// File: doc/BRIEF.md
# Near-Segment Row Cache Manager

This block sits on the memory-controller side of a DRAM whose subarray bitlines are split by an isolation device into a short, fast near segment beside the sense amplifiers and a long, slow far segment behind it. Requesters address only far-segment rows. The near segment of each subarray holds copies of far rows from that same subarray, and the block manages those copies as an inclusive cache.

A request names a bank, a subarray and a far-row index. The block looks the row up in the tag set that belongs to that subarray. It then answers with a hit flag, the slot and the physical row it opens, and emits abstract command tokens in order. A hit opens the near copy with isolation off. A miss opens the far row with isolation on. When the request's cache-allow flag is set, a miss also fills a near slot without moving any data over the channel. The far activate latches the row in the sense amplifiers. A following activate of the chosen near row stores the latched data over the shared bitlines. A parameterised number of idle cycles then passes before the precharge. Every access closes with a precharge.

Physical row numbering inside a subarray puts near slots at 0 to NEAR_ROWS-1 and far row f at NEAR_ROWS+f.

Top module: `nsc_row_cache`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid and rsp_valid are 0, and every near slot of every subarray is empty, so the first request to any row misses.
- R2: A request for a far row held in its subarray's near segment reports rsp_hit=1 with the slot index, and emits an activate-near token (cmd_kind 0) with cmd_row equal to the slot and cmd_iso=0.
- R3: A miss emits an activate-far token (cmd_kind 1) with cmd_row = NEAR_ROWS + far row and cmd_iso=1.
- R4: Tag sets are private to each (bank, subarray) pair: a row cached in one subarray is a miss in any other subarray or bank.
- R5: A fill picks the lowest-index empty slot of the set while one exists.
- R6: When the set is full, a fill replaces the least-recently-used slot, where both hits and fills count as uses. The evicted row then misses.
- R7: A miss with cache_allow=1 emits, on consecutive cycles, activate-far and then activate-destination (cmd_kind 2, cmd_row = slot, cmd_iso=1). Then follow MIG_EXTRA cycles with no token, and then a precharge (cmd_kind 3).
- R8: A miss with cache_allow=0 emits no activate-destination and leaves the tags unchanged: a later request for that row still misses.
- R9: req_ready is 0 from the cycle after acceptance up to and including the precharge cycle, and 1 in the cycle after the precharge. A request held valid meanwhile is accepted only then.
- R10: rsp_valid is 1 for exactly the one cycle after acceptance, the same cycle as the first activate token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_bank | input | BANK_W | Bank of the request |
| req_sub | input | SUB_W | Subarray within the bank |
| req_row | input | TAG_W | Far-segment row index |
| req_cache_allow | input | 1 | A miss may fill a near slot |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Row found in the near segment |
| rsp_slot | output | SLOT_W | Hit slot, or slot being filled |
| rsp_row | output | PHYS_W | Physical row opened first |
| cmd_valid | output | 1 | Command token valid |
| cmd_kind | output | 2 | 0 act-near, 1 act-far, 2 act-destination, 3 precharge |
| cmd_iso | output | 1 | Isolation device on |
| cmd_bank | output | BANK_W | Bank of the token |
| cmd_sub | output | SUB_W | Subarray of the token |
| cmd_row | output | PHYS_W | Physical row for activates, 0 for precharge |

## Verification
The two functions that can meet in one cycle are a running migration on one request and the arrival of the next request. The bench holds a second request valid from the cycle after a fill was accepted. It counts the cycles until the next response and expects exactly the activate, destination, idle and precharge cycles to pass first. It then expects that response to hit the row just filled. This shows both that the stall held and that the tag write landed before the second lookup.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
    typedef enum logic [1:0] {
        CMD_ACT_NEAR = 2'd0,
        CMD_ACT_FAR  = 2'd1,
        CMD_ACT_DEST = 2'd2,
        CMD_PRE      = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_ACT  = 3'd1,
        SQ_DEST = 3'd2,
        SQ_WAIT = 3'd3,
        SQ_PRE  = 3'd4
    } seq_e;
endpackage

// File: rtl/nsc_set_lookup.sv
module nsc_set_lookup #(
    parameter int NEAR_ROWS = 32,
    parameter int TAG_W     = 9,
    parameter int SLOT_W    = 5
) (
    input  logic [NEAR_ROWS-1:0]        vld,
    input  logic [NEAR_ROWS*TAG_W-1:0]  tags,
    input  logic [NEAR_ROWS*SLOT_W-1:0] ranks,
    input  logic [TAG_W-1:0]            row,
    output logic                        hit,
    output logic [SLOT_W-1:0]           hit_slot,
    output logic [SLOT_W-1:0]           fill_slot
);
    localparam logic [SLOT_W-1:0] OLDEST = SLOT_W'(NEAR_ROWS - 1);

    logic              have_free;
    logic [SLOT_W-1:0] free_slot;
    logic [SLOT_W-1:0] lru_slot;

    always_comb begin
        hit       = 1'b0;
        hit_slot  = '0;
        have_free = 1'b0;
        free_slot = '0;
        lru_slot  = '0;
        // descending scan so the lowest index wins
        for (int i = NEAR_ROWS - 1; i >= 0; i--) begin
            if (vld[i] && tags[i*TAG_W +: TAG_W] == row) begin
                hit      = 1'b1;
                hit_slot = SLOT_W'(i);
            end
            if (!vld[i]) begin
                have_free = 1'b1;
                free_slot = SLOT_W'(i);
            end
            if (ranks[i*SLOT_W +: SLOT_W] == OLDEST) begin
                lru_slot = SLOT_W'(i);
            end
        end
        fill_slot = have_free ? free_slot : lru_slot;
    end
endmodule

// File: rtl/nsc_lru_update.sv
module nsc_lru_update #(
    parameter int NEAR_ROWS = 32,
    parameter int SLOT_W    = 5
) (
    input  logic [NEAR_ROWS*SLOT_W-1:0] ranks_in,
    input  logic [SLOT_W-1:0]           touch,
    output logic [NEAR_ROWS*SLOT_W-1:0] ranks_out
);
    logic [SLOT_W-1:0] touch_rank;
    assign touch_rank = ranks_in[touch*SLOT_W +: SLOT_W];

    // rank 0 is most recent; slots younger than the touched one age by one
    for (genvar g = 0; g < NEAR_ROWS; g++) begin : g_slot
        logic [SLOT_W-1:0] cur;
        assign cur = ranks_in[g*SLOT_W +: SLOT_W];
        always_comb begin
            if (touch == SLOT_W'(g))
                ranks_out[g*SLOT_W +: SLOT_W] = '0;
            else if (cur < touch_rank)
                ranks_out[g*SLOT_W +: SLOT_W] = cur + 1'b1;
            else
                ranks_out[g*SLOT_W +: SLOT_W] = cur;
        end
    end
endmodule

// File: rtl/nsc_row_cache.sv
module nsc_row_cache
    import nsc_pkg::*;
#(
    parameter int BANKS     = 2,
    parameter int SUBS      = 4,
    parameter int NEAR_ROWS = 32,
    parameter int FAR_ROWS  = 480,
    parameter int MIG_EXTRA = 2,
    localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int SUB_W    = (SUBS > 1) ? $clog2(SUBS) : 1,
    localparam int TAG_W    = (FAR_ROWS > 1) ? $clog2(FAR_ROWS) : 1,
    localparam int SLOT_W   = (NEAR_ROWS > 1) ? $clog2(NEAR_ROWS) : 1,
    localparam int PHYS_W   = $clog2(NEAR_ROWS + FAR_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [SUB_W-1:0]  req_sub,
    input  logic [TAG_W-1:0]  req_row,
    input  logic              req_cache_allow,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [SLOT_W-1:0] rsp_slot,
    output logic [PHYS_W-1:0] rsp_row,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic              cmd_iso,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [SUB_W-1:0]  cmd_sub,
    output logic [PHYS_W-1:0] cmd_row
);
    localparam int SETS  = BANKS * SUBS;
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int CNT_W = (MIG_EXTRA > 1) ? $clog2(MIG_EXTRA + 1) : 1;

    typedef struct packed {
        seq_e              st;
        logic [BANK_W-1:0] bank;
        logic [SUB_W-1:0]  sub;
        logic [TAG_W-1:0]  far;
        logic              hit;
        logic              mig;
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [NEAR_ROWS-1:0]        vld_d  [SETS];
    logic [NEAR_ROWS-1:0]        vld_q  [SETS];
    logic [NEAR_ROWS*TAG_W-1:0]  tag_d  [SETS];
    logic [NEAR_ROWS*TAG_W-1:0]  tag_q  [SETS];
    logic [NEAR_ROWS*SLOT_W-1:0] rank_d [SETS];
    logic [NEAR_ROWS*SLOT_W-1:0] rank_q [SETS];

    logic [SET_W-1:0]            set_sel;
    logic                        accept;
    logic                        lk_hit;
    logic [SLOT_W-1:0]           lk_hit_slot;
    logic [SLOT_W-1:0]           lk_fill_slot;
    logic [SLOT_W-1:0]           touch_slot;
    logic [NEAR_ROWS*SLOT_W-1:0] lru_next;

    assign set_sel    = SET_W'(int'(req_bank) * SUBS + int'(req_sub));
    assign accept     = req_valid && (seq_q.st == SQ_IDLE);
    assign touch_slot = lk_hit ? lk_hit_slot : lk_fill_slot;

    nsc_set_lookup #(
        .NEAR_ROWS(NEAR_ROWS), .TAG_W(TAG_W), .SLOT_W(SLOT_W)
    ) u_lookup (
        .vld      (vld_q[set_sel]),
        .tags     (tag_q[set_sel]),
        .ranks    (rank_q[set_sel]),
        .row      (req_row),
        .hit      (lk_hit),
        .hit_slot (lk_hit_slot),
        .fill_slot(lk_fill_slot)
    );

    nsc_lru_update #(
        .NEAR_ROWS(NEAR_ROWS), .SLOT_W(SLOT_W)
    ) u_lru (
        .ranks_in (rank_q[set_sel]),
        .touch    (touch_slot),
        .ranks_out(lru_next)
    );

    always_comb begin
        seq_d  = seq_q;
        vld_d  = vld_q;
        tag_d  = tag_q;
        rank_d = rank_q;
        unique case (seq_q.st)
            SQ_IDLE: begin
                if (accept) begin
                    seq_d.st   = SQ_ACT;
                    seq_d.bank = req_bank;
                    seq_d.sub  = req_sub;
                    seq_d.far  = req_row;
                    seq_d.hit  = lk_hit;
                    seq_d.mig  = !lk_hit && req_cache_allow;
                    seq_d.slot = touch_slot;
                    if (lk_hit) begin
                        rank_d[set_sel] = lru_next;
                    end else if (req_cache_allow) begin
                        vld_d[set_sel][lk_fill_slot] = 1'b1;
                        tag_d[set_sel][lk_fill_slot*TAG_W +: TAG_W] = req_row;
                        rank_d[set_sel] = lru_next;
                    end
                end
            end
            SQ_ACT:  seq_d.st = seq_q.mig ? SQ_DEST : SQ_PRE;
            SQ_DEST: begin
                if (MIG_EXTRA == 0) begin
                    seq_d.st = SQ_PRE;
                end else begin
                    seq_d.st  = SQ_WAIT;
                    seq_d.cnt = CNT_W'(MIG_EXTRA - 1);
                end
            end
            SQ_WAIT: begin
                if (seq_q.cnt == '0) seq_d.st = SQ_PRE;
                else                 seq_d.cnt = seq_q.cnt - 1'b1;
            end
            SQ_PRE:  seq_d.st = SQ_IDLE;
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= SQ_IDLE;
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                tag_q[s] <= '0;
                for (int k = 0; k < NEAR_ROWS; k++) begin
                    rank_q[s][k*SLOT_W +: SLOT_W] <= SLOT_W'(k);
                end
            end
        end else begin
            seq_q  <= seq_d;
            vld_q  <= vld_d;
            tag_q  <= tag_d;
            rank_q <= rank_d;
        end
    end

    logic [PHYS_W-1:0] near_row;
    logic [PHYS_W-1:0] far_row;
    assign near_row = PHYS_W'(seq_q.slot);
    assign far_row  = PHYS_W'(NEAR_ROWS) + PHYS_W'(seq_q.far);

    assign req_ready = (seq_q.st == SQ_IDLE);
    assign rsp_valid = (seq_q.st == SQ_ACT);
    assign rsp_hit   = seq_q.hit;
    assign rsp_slot  = seq_q.slot;
    assign rsp_row   = seq_q.hit ? near_row : far_row;
    assign cmd_valid = (seq_q.st == SQ_ACT) || (seq_q.st == SQ_DEST) || (seq_q.st == SQ_PRE);
    assign cmd_iso   = cmd_valid && !seq_q.hit;
    assign cmd_bank  = seq_q.bank;
    assign cmd_sub   = seq_q.sub;

    always_comb begin
        cmd_kind = CMD_PRE;
        cmd_row  = '0;
        if (seq_q.st == SQ_ACT) begin
            cmd_kind = seq_q.hit ? CMD_ACT_NEAR : CMD_ACT_FAR;
            cmd_row  = seq_q.hit ? near_row : far_row;
        end else if (seq_q.st == SQ_DEST) begin
            cmd_kind = CMD_ACT_DEST;
            cmd_row  = near_row;
        end
    end
endmodule

// File: rtl/nsc_row_cache_chk.sv
module nsc_row_cache_chk
    import nsc_pkg::*;
#(
    parameter int NEAR_ROWS = 32,
    parameter int PHYS_W    = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [PHYS_W-1:0] rsp_row,
    input logic              cmd_valid,
    input logic [1:0]        cmd_kind,
    input logic              cmd_iso
);
    // R2
    near_iso_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_ACT_NEAR) |-> !cmd_iso);

    // R3
    far_iso_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_ACT_FAR) |-> cmd_iso);

    // R7
    dest_after_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_ACT_DEST) |->
            $past(cmd_valid && cmd_kind == CMD_ACT_FAR));

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    rsp_with_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (cmd_valid && (cmd_kind == CMD_ACT_NEAR || cmd_kind == CMD_ACT_FAR)));

    // R2
    hit_row_near_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_row < PHYS_W'(NEAR_ROWS)));
endmodule

bind nsc_row_cache nsc_row_cache_chk #(
    .NEAR_ROWS(NEAR_ROWS), .PHYS_W(PHYS_W)
) u_chk (.*);

// File: tb/nsc_row_cache_tb.sv
module nsc_row_cache_tb;
    localparam int NEAR = 4;
    localparam int FAR  = 60;
    localparam int MIG  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [0:0] req_bank = '0;
    logic [0:0] req_sub = '0;
    logic [5:0] req_row = '0;
    logic       req_cache_allow = 1'b0;
    logic       rsp_valid, rsp_hit, cmd_valid, cmd_iso;
    logic [1:0] rsp_slot;
    logic [5:0] rsp_row, cmd_row;
    logic [1:0] cmd_kind;
    logic [0:0] cmd_bank, cmd_sub;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    nsc_row_cache #(
        .BANKS(2), .SUBS(2), .NEAR_ROWS(NEAR), .FAR_ROWS(FAR), .MIG_EXTRA(MIG)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_sub(req_sub), .req_row(req_row),
        .req_cache_allow(req_cache_allow), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_slot(rsp_slot), .rsp_row(rsp_row), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_iso(cmd_iso), .cmd_bank(cmd_bank),
        .cmd_sub(cmd_sub), .cmd_row(cmd_row)
    );

    // {bank, sub, row[5:0], allow, exp_hit, exp_slot[1:0], tag[2:0]}
    localparam logic [14:0] VECS [15] = '{
        {1'b0, 1'b0, 6'd10, 1'b1, 1'b0, 2'd0, 3'd1},
        {1'b0, 1'b0, 6'd10, 1'b1, 1'b1, 2'd0, 3'd0},
        {1'b0, 1'b0, 6'd11, 1'b1, 1'b0, 2'd1, 3'd1},
        {1'b0, 1'b0, 6'd12, 1'b0, 1'b0, 2'd0, 3'd3},
        {1'b0, 1'b0, 6'd12, 1'b1, 1'b0, 2'd2, 3'd3},
        {1'b0, 1'b0, 6'd13, 1'b1, 1'b0, 2'd3, 3'd1},
        {1'b0, 1'b0, 6'd10, 1'b1, 1'b1, 2'd0, 3'd0},
        {1'b0, 1'b0, 6'd14, 1'b1, 1'b0, 2'd1, 3'd2},
        {1'b0, 1'b0, 6'd11, 1'b0, 1'b0, 2'd0, 3'd2},
        {1'b0, 1'b1, 6'd10, 1'b1, 1'b0, 2'd0, 3'd4},
        {1'b1, 1'b0, 6'd10, 1'b1, 1'b0, 2'd0, 3'd4},
        {1'b0, 1'b0, 6'd14, 1'b1, 1'b1, 2'd1, 3'd0},
        {1'b0, 1'b0, 6'd12, 1'b1, 1'b1, 2'd2, 3'd0},
        {1'b0, 1'b0, 6'd15, 1'b1, 1'b0, 2'd3, 3'd2},
        {1'b0, 1'b0, 6'd13, 1'b0, 1'b0, 2'd0, 3'd5}
    };

    function automatic string tag_name(input logic [2:0] c);
        case (c)
            3'd0:    return "R2";
            3'd1:    return "R5";
            3'd2:    return "R6";
            3'd3:    return "R8";
            3'd4:    return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // called at a negedge; returns at a negedge with the block idle again
    task automatic run_req(input logic b, input logic s, input logic [5:0] row,
                           input logic allow, input logic exp_hit,
                           input logic [1:0] exp_slot, input string tg);
        logic mig;
        mig = !exp_hit && allow;
        while (!req_ready) @(negedge clk);
        req_bank = b; req_sub = s; req_row = row; req_cache_allow = allow;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R10", int'(rsp_valid), 1);
        chk(rsp_hit == exp_hit, tg, int'(rsp_hit), int'(exp_hit));
        if (exp_hit) begin
            chk(cmd_kind == 2'd0 && !cmd_iso, "R2", int'(cmd_kind), 0);
            chk(cmd_row == 6'(exp_slot), "R2", int'(cmd_row), int'(exp_slot));
        end else begin
            chk(cmd_kind == 2'd1 && cmd_iso, "R3", int'(cmd_kind), 1);
            chk(cmd_row == 6'(NEAR) + row, "R3", int'(cmd_row), NEAR + int'(row));
        end
        if (exp_hit || allow)
            chk(rsp_slot == exp_slot, tg, int'(rsp_slot), int'(exp_slot));
        chk(cmd_bank == b && cmd_sub == s, "R4", int'({cmd_bank, cmd_sub}), int'({b, s}));
        if (mig) begin
            @(negedge clk);
            chk(cmd_valid && cmd_kind == 2'd2, "R7", int'(cmd_kind), 2);
            chk(cmd_row == 6'(exp_slot) && cmd_iso, "R7", int'(cmd_row), int'(exp_slot));
            for (int k = 0; k < MIG; k++) begin
                @(negedge clk);
                chk(!cmd_valid && !req_ready, "R7", int'(cmd_valid), 0);
            end
        end
        @(negedge clk);
        chk(cmd_valid && cmd_kind == 2'd3, "R7", int'(cmd_kind), 3);
        chk(!req_ready && !rsp_valid, "R9", int'(req_ready), 0);
        @(negedge clk);
        chk(req_ready && !cmd_valid, "R9", int'(req_ready), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !cmd_valid && !rsp_valid, "R1", int'(req_ready), 1);

        for (int v = 0; v < 15; v++) begin
            logic [14:0] e;
            e = VECS[v];
            run_req(e[14], e[13], e[12:7], e[6], e[5], e[4:3], tag_name(e[2:0]));
        end

        // R9: request held valid behind a running migration
        begin
            int gap;
            req_bank = 1'b1; req_sub = 1'b1; req_row = 6'd20; req_cache_allow = 1'b1;
            req_valid = 1'b1;
            @(negedge clk);
            chk(rsp_valid && !rsp_hit, "R9", int'(rsp_hit), 0);
            req_cache_allow = 1'b0;
            gap = 0;
            do begin
                @(negedge clk);
                gap++;
            end while (!rsp_valid && gap < 20);
            req_valid = 1'b0;
            chk(gap == 4 + MIG, "R9", gap, 4 + MIG);
            chk(rsp_hit == 1'b1 && rsp_slot == 2'd0, "R9", int'(rsp_hit), 1);
            while (!req_ready) @(negedge clk);
        end

        // R1: reset mid-run empties all sets
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !cmd_valid, "R1", int'(req_ready), 1);
        run_req(1'b0, 1'b0, 6'd10, 1'b1, 1'b0, 2'd0, "R1");

        summary();
    end
endmodule